// File: doc/BRIEF.md
# Sector-to-Memory DMA Controller

This block lets a host fetch one fixed-size sector from block storage into main memory with one programmed command. The host loads a logical block number and a destination byte address through a small word-indexed register port, then writes a read command. The controller splits the logical block number into a surface, a track and a sector index using parameterized geometry. It presents that triple to a sector source while pulling the sector's words from it. It then writes each word into memory through a valid/ready write master. The host does not move any data while this happens.

When the last word has been accepted by memory, the controller raises its interrupt line and reports completion in a status word. It also handles two error cases. A logical block number beyond the configured capacity finishes at once with an error and no memory traffic. A command that arrives while a transfer is running is dropped and flagged.

Register port word indices: 0 command, 1 logical block number, 2 destination address, 3 status. Status bits: bit0 busy, bit1 done, bit2 command-while-busy error, bit3 out-of-range error.

Top module: `blk_sector_dma`

## Requirements
- R1: After reset, the status word reads 0, `irq` is low, and neither `dma_valid` nor `src_active` is asserted.
- R2: Writing 0x01 in bits [7:0] to index 0 while idle, with an in-range block number, starts a transfer and sets status bit0 (busy). Any other command code leaves status at 0 and starts nothing.
- R3: During a transfer, `src_sector` = block mod SECT_PER_TRK, `src_track` = (block div SECT_PER_TRK) mod TRK_PER_SURF, and `src_surface` = block div (SECT_PER_TRK*TRK_PER_SURF).
- R4: A transfer writes exactly SECTOR_BYTES/4 words in source order. The first word goes to the destination address. The address rises by 4 after each accepted handshake, and address and data stay stable while `dma_ready` is low.
- R5: After the last word is accepted, busy clears, status bit1 (done) sets and `irq` goes high.
- R6: A status read (index 3) clears done and `irq` from the next cycle. A status write with bit1 set clears done, bit2 and bit3.
- R7: A read command written while busy is ignored: the running transfer is unaffected, and status bit2 sets.
- R8: A block number at or above SECT_PER_TRK*TRK_PER_SURF*SURFACES sets status bit3 and done and raises `irq`, without any memory write or source activity.
- R9: Indices 1 and 2 read back the stored block number and destination address; destination bits [1:0] read as 0.
- R10: The source is only accepted when the single word buffer is empty, so every accepted source word appears on the memory master the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| irq | output | 1 | Completion interrupt |
| src_active | output | 1 | Sector fetch in progress |
| src_surface | output | SURF_W | Translated surface |
| src_track | output | TRK_W | Translated track |
| src_sector | output | SEC_W | Translated sector index |
| src_ready | output | 1 | Controller accepts a source word |
| src_valid | input | 1 | Source word present |
| src_data | input | 32 | Source word |
| dma_valid | output | 1 | Memory write request |
| dma_addr | output | ADDR_W | Memory byte address |
| dma_wdata | output | 32 | Memory write word |
| dma_ready | input | 1 | Memory accepts the write |

## Verification
The bench sweeps every logical block of a small geometry. Each block has its own destination, and source data encodes the presented triple, so a mistake in the mod/div chain shows up as wrong data in memory. Both sides stall on a pseudo-random pattern. A design that dropped or repeated a word under backpressure, or stepped its address wrongly, would leave gaps or overwrite the guard words around the sector. Two out-of-range numbers, including the first one past capacity, catch an off-by-one bound check; such a design would write memory or never finish. A second command issued during a transfer, after the block register has been changed, exposes a design that restarts rather than ignoring it. Separate checks cover read-clear and write-clear of the status bits.

// File: rtl/blk_sector_dma.sv
module blk_sector_dma #(
  parameter int SECTOR_BYTES = 512,
  parameter int SECT_PER_TRK = 32,
  parameter int TRK_PER_SURF = 1024,
  parameter int SURFACES     = 4,
  parameter int ADDR_W       = 32,
  localparam int SEC_W  = (SECT_PER_TRK > 1) ? $clog2(SECT_PER_TRK) : 1,
  localparam int TRK_W  = (TRK_PER_SURF > 1) ? $clog2(TRK_PER_SURF) : 1,
  localparam int SURF_W = (SURFACES > 1) ? $clog2(SURFACES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              src_active,
  output logic [SURF_W-1:0] src_surface,
  output logic [TRK_W-1:0]  src_track,
  output logic [SEC_W-1:0]  src_sector,
  output logic              src_ready,
  input  logic              src_valid,
  input  logic [31:0]       src_data,
  output logic              dma_valid,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [31:0]       dma_wdata,
  input  logic              dma_ready
);
  localparam int WORDS = SECTOR_BYTES / 4;
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);
  localparam logic [31:0] SPT_L = 32'(SECT_PER_TRK);
  localparam logic [31:0] TPS_L = 32'(TRK_PER_SURF);
  localparam logic [31:0] CAP_L = 32'(SECT_PER_TRK * TRK_PER_SURF * SURFACES);

  logic              busy, done, err_busy, err_range;
  logic [31:0]       lba_q;
  logic [ADDR_W-1:0] dest_q, addr_q;
  logic [31:0]       buf_q;
  logic              buf_v;
  logic [CNT_W-1:0]  sent_q;
  logic [SEC_W-1:0]  sec_q;
  logic [TRK_W-1:0]  trk_q;
  logic [SURF_W-1:0] surf_q;

  wire cmd_rd    = reg_wr && reg_sel == 2'd0 && reg_wdata[7:0] == 8'h01;
  wire start     = cmd_rd && !busy;
  wire in_range  = lba_q < CAP_L;
  wire take      = src_valid && src_ready;
  wire put       = buf_v && dma_ready;
  wire last      = put && sent_q == LAST_IDX;
  wire stat_clr  = reg_wr && reg_sel == 2'd3 && reg_wdata[1];
  wire stat_rd   = reg_rd && reg_sel == 2'd3;

  assign src_ready   = busy && !buf_v;
  assign src_active  = busy;
  assign src_sector  = sec_q;
  assign src_track   = trk_q;
  assign src_surface = surf_q;
  assign dma_valid   = buf_v;
  assign dma_addr    = addr_q;
  assign dma_wdata   = buf_q;
  assign irq         = done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lba_q  <= '0;
      dest_q <= '0;
    end else if (reg_wr) begin
      if (reg_sel == 2'd1) lba_q  <= reg_wdata;
      if (reg_sel == 2'd2) dest_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr_q <= '0;
      sent_q <= '0;
      sec_q  <= '0;
      trk_q  <= '0;
      surf_q <= '0;
      buf_v  <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (start && in_range) begin
        busy   <= 1'b1;
        addr_q <= dest_q;
        sent_q <= '0;
        sec_q  <= SEC_W'(lba_q % SPT_L);
        trk_q  <= TRK_W'((lba_q / SPT_L) % TPS_L);
        surf_q <= SURF_W'(lba_q / (SPT_L * TPS_L));
      end
      if (take) begin
        buf_v <= 1'b1;
        buf_q <= src_data;
      end
      if (put) begin
        buf_v  <= 1'b0;
        addr_q <= addr_q + ADDR_W'(4);
        sent_q <= sent_q + CNT_W'(1);
      end
      if (last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      err_busy  <= 1'b0;
      err_range <= 1'b0;
    end else begin
      if (last || (start && !in_range)) done <= 1'b1;
      else if (stat_clr || stat_rd)     done <= 1'b0;
      if (start && !in_range) err_range <= 1'b1;
      else if (stat_clr)      err_range <= 1'b0;
      if (cmd_rd && busy)     err_busy  <= 1'b1;
      else if (stat_clr)      err_busy  <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      2'd1:    reg_rdata = lba_q;
      2'd2:    reg_rdata = 32'(dest_q);
      2'd3:    reg_rdata = {28'd0, err_range, err_busy, done, busy};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module blk_sector_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              busy,
  input logic              err_busy,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [31:0]       reg_wdata,
  input logic              src_valid,
  input logic              src_ready,
  input logic              dma_valid,
  input logic              dma_ready,
  input logic [ADDR_W-1:0] dma_addr,
  input logic [31:0]       dma_wdata
);
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && dma_ready |=> dma_addr == $past(dma_addr) + ADDR_W'(4));

  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_wdata));

  a_r10_src_to_dma: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready |=> dma_valid);

  a_r7_busy_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel == 2'd0 && reg_wdata[7:0] == 8'h01 && busy |=> err_busy && busy);

  a_r5_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy && !dma_valid);
endmodule

bind blk_sector_dma blk_sector_dma_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .busy(busy), .err_busy(err_busy),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .src_valid(src_valid), .src_ready(src_ready),
  .dma_valid(dma_valid), .dma_ready(dma_ready),
  .dma_addr(dma_addr), .dma_wdata(dma_wdata)
);

// File: tb/blk_sector_dma_tb.sv
module blk_sector_dma_tb_top;
  localparam int SB = 32, SPT = 4, TPS = 3, SF = 2;
  localparam int WORDS = SB / 4;
  localparam int CAP = SPT * TPS * SF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, src_active, src_ready, dma_valid;
  logic [0:0] src_surface;
  logic [1:0] src_track, src_sector;
  logic src_valid = 1'b0, dma_ready = 1'b0;
  logic [31:0] src_data = '0, dma_addr, dma_wdata;

  int checks = 0, fails = 0, cyc = 0, wr_cnt = 0, src_idx = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] mem [0:255];
  bit src_seen = 1'b0;

  always #2.5 clk = ~clk;

  blk_sector_dma #(.SECTOR_BYTES(SB), .SECT_PER_TRK(SPT), .TRK_PER_SURF(TPS),
                   .SURFACES(SF), .ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .src_active(src_active), .src_surface(src_surface), .src_track(src_track),
    .src_sector(src_sector), .src_ready(src_ready), .src_valid(src_valid),
    .src_data(src_data), .dma_valid(dma_valid), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_ready(dma_ready));

  function automatic logic [31:0] word_of(int s, int t, int c, int i);
    return 32'hA500_0000 | 32'(s << 20) | 32'(t << 16) | 32'(c << 8) | 32'(i);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dma_ready = lfsr[0] | lfsr[3];
    if (!src_active) src_idx = 0;
    else src_seen = 1'b1;
    src_valid = src_active && (lfsr[5] | lfsr[1]);
    src_data = word_of(int'(src_surface), int'(src_track), int'(src_sector), src_idx);
    if (src_valid && src_ready) src_idx++;
    if (dma_valid && dma_ready) begin
      mem[dma_addr[9:2]] = dma_wdata;
      wr_cnt++;
    end
  end

  task automatic reg_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(string req);
    int n = 0;
    while (!irq && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(irq, req, 32'(irq), 32'd1);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_BEEF;
  endtask

  task automatic check_sector(int lba, int base, string req);
    int s = lba / (SPT * TPS), t = (lba / SPT) % TPS, c = lba % SPT;
    for (int i = 0; i < WORDS; i++)
      check(mem[base + i] == word_of(s, t, c, i), req, mem[base + i], word_of(s, t, c, i));
    check(mem[base - 1] == 32'hDEAD_BEEF, req, mem[base - 1], 32'hDEAD_BEEF);
    check(mem[base + WORDS] == 32'hDEAD_BEEF, req, mem[base + WORDS], 32'hDEAD_BEEF);
  endtask

  initial begin
    logic [31:0] r;
    int w0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!irq, "R1 irq", 32'(irq), 0);
    check(!dma_valid && !src_active, "R1 idle outputs", {30'd0, dma_valid, src_active}, 0);
    reg_read(2'd3, r);
    check(r == 0, "R1 status", r, 0);

    // R9 readback
    reg_write(2'd1, 32'h0000_1234);
    reg_write(2'd2, 32'h0000_0107);
    reg_read(2'd1, r);
    check(r == 32'h1234, "R9 lba readback", r, 32'h1234);
    reg_read(2'd2, r);
    check(r == 32'h104, "R9 dest readback", r, 32'h104);

    // R2 unknown command code ignored
    reg_write(2'd1, 32'd3);
    reg_write(2'd0, 32'h02);
    repeat (10) @(negedge clk);
    reg_read(2'd3, r);
    check(r == 0 && !src_active && !irq, "R2 other code ignored", r, 0);

    // R2-R6 sweep over every block
    for (int lba = 0; lba < CAP; lba++) begin
      int base = 8 + lba * 3;
      clear_mem();
      w0 = wr_cnt;
      reg_write(2'd1, 32'(lba));
      reg_write(2'd2, 32'(base * 4));
      reg_write(2'd0, 32'h01);
      reg_read(2'd3, r);
      check(r[0] == 1'b1, "R2 busy after start", r, 32'd1);
      check(int'(src_sector) == lba % SPT, "R3 sector", 32'(src_sector), 32'(lba % SPT));
      check(int'(src_track) == (lba / SPT) % TPS, "R3 track", 32'(src_track), 32'((lba / SPT) % TPS));
      check(int'(src_surface) == lba / (SPT * TPS), "R3 surface", 32'(src_surface), 32'(lba / (SPT * TPS)));
      wait_irq("R5 irq on completion");
      reg_read(2'd3, r);
      check(r == 32'h2, "R5 status done", r, 32'h2);
      check(!irq, "R6 read clears irq", 32'(irq), 0);
      check(wr_cnt - w0 == WORDS, "R4 word count", 32'(wr_cnt - w0), 32'(WORDS));
      check_sector(lba, base, "R4 R3 sector data");
    end

    // R8 out-of-range blocks
    foreach (int_vals[k]) ;
    for (int k = 0; k < 2; k++) begin
      int bad = (k == 0) ? CAP : 1000;
      w0 = wr_cnt;
      src_seen = 1'b0;
      reg_write(2'd1, 32'(bad));
      reg_write(2'd0, 32'h01);
      wait_irq("R8 irq on range error");
      reg_read(2'd3, r);
      check(r == 32'hA, "R8 status range+done", r, 32'hA);
      check(wr_cnt == w0 && !src_seen, "R8 no traffic", 32'(wr_cnt - w0), 0);
      reg_read(2'd3, r);
      check(r == 32'h8, "R6 read leaves error", r, 32'h8);
      reg_write(2'd3, 32'h2);
      reg_read(2'd3, r);
      check(r == 0, "R6 write clears errors", r, 0);
    end

    // R7 command while busy
    clear_mem();
    w0 = wr_cnt;
    reg_write(2'd1, 32'd7);
    reg_write(2'd2, 32'd40 * 4);
    reg_write(2'd0, 32'h01);
    reg_write(2'd1, 32'd20);
    reg_write(2'd0, 32'h01);
    reg_read(2'd3, r);
    check(r == 32'h5, "R7 busy error flag", r, 32'h5);
    wait_irq("R7 irq");
    reg_read(2'd3, r);
    check(r == 32'h6, "R7 status after", r, 32'h6);
    repeat (20) @(negedge clk);
    check(wr_cnt - w0 == WORDS && !src_active, "R7 single transfer", 32'(wr_cnt - w0), 32'(WORDS));
    check_sector(7, 40, "R7 original block kept");
    reg_write(2'd3, 32'h2);
    reg_read(2'd3, r);
    check(r == 0, "R6 clear busy error", r, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
  int int_vals[1];
endmodule